// File: doc/BRIEF.md
# I2C Loopback Target

This block is an I2C target that runs entirely from a fast system clock. It oversamples the SCL and SDA lines, finds START and STOP conditions, and answers one fixed 7-bit address. A controller writes a few bytes into a receive store. When the write ends with a STOP, the block turns each stored byte into a reply byte one greater, and places it in a transmit store. A later read from the controller returns those reply bytes.

Both bus lines are open-drain. Each one is modelled as a pin input plus an output enable, and an asserted enable pulls the line low. The block never stretches the clock, so its SCL enable stays low. A count output shows how many bytes the current write has stored so far.

Stores and indices wrap at a power-of-two depth. A write of exactly the store depth therefore leaves the count at zero, and the STOP that follows copies nothing. Each address phase restarts its own index: the receive index for a write, the transmit index for a read.

Top module: `i2c_loop_target`

## Requirements
- R1: After reset `sda_oe` and `scl_oe` are 0 and `rx_count` is 0. All transmit entries hold 0x00, so a read issued before any write returns 0x00 bytes.
- R2: An address byte whose upper seven bits equal OWN_ADDR (default 0x10) is acknowledged. The byte is 0x20 for a write and 0x21 for a read, with bit 0 as the direction (1 = read). Acknowledging means holding SDA low through the ninth SCL high period.
- R3: The address byte 0x00 is also acknowledged, and it is treated as a write.
- R4: Any other address byte is not acknowledged. The block then ignores the bus until the next START: it acknowledges no further bytes, stores nothing and leaves `rx_count` unchanged.
- R5: In a write, each data byte is shifted in MSB first and acknowledged. It is stored at the receive index, which then advances modulo RX_DEPTH (default 8). `rx_count` shows that index.
- R6: A STOP after a write whose index N is non-zero sets transmit entry k to (receive entry k + 1) mod 256 for each k < N. Higher transmit entries keep their old values, and `rx_count` returns to 0.
- R7: When a write leaves the index at 0, including a write of exactly RX_DEPTH bytes, the STOP copies nothing.
- R8: A read returns transmit entries MSB first, starting from entry 0 and moving on after each controller ACK. The index wraps modulo TX_DEPTH, so byte TX_DEPTH+1 repeats entry 0.
- R9: A controller NACK after a read byte ends the transfer. SDA stays released from then on.
- R10: A repeated START restarts the address phase in any state. Without a STOP no copy takes place, and `rx_count` keeps its value.
- R11: `scl_oe` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low (always 0) |
| sda_oe | output | 1 | Pull SDA low |
| rx_count | output | $clog2(RX_DEPTH) | Bytes stored by the current write, modulo RX_DEPTH |

## Verification
Each pin change takes three system clocks to have an effect: two synchronizer stages, then the control register. An ACK, a data bit or a release of SDA therefore appears about three clocks after the SCL fall that triggers it. The bench holds every SCL phase for ten clocks. It reads SDA halfway through each high phase, well after any such change has settled and well before the next one. `rx_count` and transmit contents are checked only after the last bus edge of a step has had ten clocks to propagate. Writes are swept over every length from 1 to 9, and each is followed by a read that walks the whole transmit store against a model computed in the bench.

// File: rtl/i2c_lt_pkg.sv
package i2c_lt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } lt_state_e;
endpackage

// File: rtl/i2c_lt_sync.sv
module i2c_lt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_lt_sync: STAGES must be at least 2");
   end

   // bit 1 = SCL, bit 0 = SDA; idle bus is high
   logic [STAGES-1:0][1:0] chain;
   logic [1:0]             prev;
   logic [1:0]             cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 2'b11;
      end else begin
         chain <= {chain[STAGES-2:0], {scl_i, sda_i}};
         prev  <= chain[STAGES-1];
      end
   end

   assign cur      = chain[STAGES-1];
   assign scl_q    = cur[1];
   assign sda_q    = cur[0];
   assign scl_rise = cur[1] & ~prev[1];
   assign scl_fall = ~cur[1] & prev[1];
   assign start_ev = cur[1] & prev[1] & prev[0] & ~cur[0];
   assign stop_ev  = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/i2c_lt_rxbuf.sv
module i2c_lt_rxbuf
   import i2c_lt_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IW-1:0]                wr_idx,
   input  logic [BYTE_W-1:0]            wr_data,
   output logic [DEPTH-1:0][BYTE_W-1:0] mem_o
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem_o[i] <= '0;
         else if (wr_en && (wr_idx == IW'(i)))
            mem_o[i] <= wr_data;
      end
   end
endmodule

// File: rtl/i2c_lt_txbuf.sv
module i2c_lt_txbuf
   import i2c_lt_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int SRC_DEPTH = 8,
   localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int SIW = (SRC_DEPTH > 1) ? $clog2(SRC_DEPTH) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             copy_en,
   input  logic [SIW-1:0]                   copy_cnt,
   input  logic [SRC_DEPTH-1:0][BYTE_W-1:0] src,
   input  logic [IW-1:0]                    rd_idx,
   output logic [BYTE_W-1:0]                rd_data
);
   logic [DEPTH-1:0][BYTE_W-1:0] mem;

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      if (i < SRC_DEPTH) begin : g_fed
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (copy_en && (copy_cnt > SIW'(i)))
               mem[i] <= src[i] + 8'd1;
         end
      end else begin : g_unfed
         assign mem[i] = '0;
      end
   end

   if (DEPTH > 1) begin : g_sel
      assign rd_data = mem[rd_idx];
   end else begin : g_one
      assign rd_data = mem[0];
   end
endmodule

// File: rtl/i2c_loop_target.sv
module i2c_loop_target
   import i2c_lt_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR    = 7'h10,
   parameter int         RX_DEPTH    = 8,
   parameter int         TX_DEPTH    = 8,
   parameter int         SYNC_STAGES = 2,
   localparam int RIW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1,
   localparam int TIW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           scl_i,
   input  logic           sda_i,
   output logic           scl_oe,
   output logic           sda_oe,
   output logic [RIW-1:0] rx_count
);
   localparam logic [RIW-1:0] RMASK = RIW'(RX_DEPTH - 1);
   localparam logic [TIW-1:0] TMASK = TIW'(TX_DEPTH - 1);

   if (RX_DEPTH < 1 || RX_DEPTH > 32 || (RX_DEPTH & (RX_DEPTH - 1)) != 0) begin : g_bad_rx
      $error("i2c_loop_target: RX_DEPTH must be a power of two from 1 to 32");
   end
   if (TX_DEPTH < 1 || TX_DEPTH > 32 || (TX_DEPTH & (TX_DEPTH - 1)) != 0) begin : g_bad_tx
      $error("i2c_loop_target: TX_DEPTH must be a power of two from 1 to 32");
   end

   logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

   i2c_lt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   lt_state_e         state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              is_read;
   logic              ack_seen;
   logic              sda_oe_q;
   logic [RIW-1:0]    rx_idx;
   logic [TIW-1:0]    tx_idx;

   logic                            wr_en, copy_en, addr_hit;
   logic [RX_DEPTH-1:0][BYTE_W-1:0] rx_mem;
   logic [BYTE_W-1:0]               tx_data;

   assign addr_hit = (shreg[7:1] == OWN_ADDR) || (shreg == 8'h00);
   assign copy_en  = stop_ev && (rx_idx != '0);
   assign wr_en    = !stop_ev && !start_ev && (state == ST_RX) && scl_fall && (bitcnt == 4'd8);

   i2c_lt_rxbuf #(.DEPTH(RX_DEPTH)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(rx_idx),
      .wr_data(shreg), .mem_o(rx_mem)
   );

   i2c_lt_txbuf #(.DEPTH(TX_DEPTH), .SRC_DEPTH(RX_DEPTH)) u_txbuf (
      .clk(clk), .rst_n(rst_n), .copy_en(copy_en), .copy_cnt(rx_idx),
      .src(rx_mem), .rd_idx(tx_idx), .rd_data(tx_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         is_read  <= 1'b0;
         ack_seen <= 1'b0;
         sda_oe_q <= 1'b0;
         rx_idx   <= '0;
         tx_idx   <= '0;
      end else if (stop_ev) begin
         state    <= ST_IDLE;
         sda_oe_q <= 1'b0;
         if (copy_en) rx_idx <= '0;
      end else if (start_ev) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         sda_oe_q <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_RX: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  shreg  <= {shreg[6:0], sda_q};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  bitcnt <= '0;
                  if (state == ST_RX) begin
                     rx_idx   <= (rx_idx + RIW'(1)) & RMASK;
                     sda_oe_q <= 1'b1;
                     state    <= ST_RX_ACK;
                  end else if (addr_hit) begin
                     is_read  <= shreg[0];
                     sda_oe_q <= 1'b1;
                     state    <= ST_ADDR_ACK;
                     if (shreg[0]) tx_idx <= '0;
                     else          rx_idx <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ADDR_ACK, ST_RX_ACK: begin
               if (scl_fall) begin
                  if (state == ST_ADDR_ACK && is_read) begin
                     shreg    <= tx_data;
                     sda_oe_q <= ~tx_data[7];
                     tx_idx   <= (tx_idx + TIW'(1)) & TMASK;
                     bitcnt   <= 4'd1;
                     state    <= ST_TX;
                  end else begin
                     sda_oe_q <= 1'b0;
                     bitcnt   <= '0;
                     state    <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe_q <= 1'b0;
                     state    <= ST_TX_ACK;
                  end else begin
                     sda_oe_q <= ~shreg[6];
                     shreg    <= {shreg[6:0], 1'b0};
                     bitcnt   <= bitcnt + 4'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  ack_seen <= ~sda_q;
               end else if (scl_fall) begin
                  if (ack_seen) begin
                     shreg    <= tx_data;
                     sda_oe_q <= ~tx_data[7];
                     tx_idx   <= (tx_idx + TIW'(1)) & TMASK;
                     bitcnt   <= 4'd1;
                     state    <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe   = sda_oe_q;
   assign scl_oe   = 1'b0;
   assign rx_count = rx_idx;

   // R5
   rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rx_idx == (($past(rx_idx) + RIW'(1)) & RMASK));

   // R6
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (rx_count == '0) && (state == ST_IDLE) && !sda_oe);

   // R10
   restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev && !stop_ev) |=> (state == ST_ADDR) && (bitcnt == 4'd0) && !sda_oe);

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R9
   tx_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK) |-> !sda_oe);
endmodule

// File: tb/i2c_loop_target_bench.sv
module i2c_loop_target_bench;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic scl_oe, sda_oe;
   logic [2:0] rx_count;
   logic scl_i, sda_i;

   int checks = 0;
   int errors = 0;
   bit scl_driven = 1'b0;
   bit done = 1'b0;

   logic [7:0] model [8];
   logic [7:0] rx_model [8];
   logic [7:0] wdata [16];

   always #2 clk = ~clk;

   assign scl_i = scl_m & ~scl_oe;
   assign sda_i = sda_m & ~sda_oe;

   i2c_loop_target u_i2c_loop_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_count(rx_count)
   );

   always @(negedge clk) if (rst_n && scl_oe) scl_driven = 1'b1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (Q) @(negedge clk);
   endtask

   task automatic send_start();
      sda_m = 1'b1; half(); scl_m = 1'b1; half();
      sda_m = 1'b0; half(); scl_m = 1'b0; half();
   endtask

   task automatic send_stop();
      sda_m = 1'b0; half(); scl_m = 1'b1; half();
      sda_m = 1'b1; half();
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; half(); scl_m = 1'b1; half(); half(); scl_m = 1'b0;
   endtask

   task automatic bit_in(output logic v);
      sda_m = 1'b1; half(); scl_m = 1'b1; half(); v = sda_i; half(); scl_m = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] b, output logic ack);
      logic v;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(v);
      ack = ~v;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] b);
      logic v;
      for (int i = 7; i >= 0; i--) begin
         bit_in(v);
         b[i] = v;
      end
      bit_out(~give_ack);
   endtask

   // address phase plus n data bytes from wdata, no STOP
   task automatic wr_xfer(input string req, input logic [7:0] ab, input int n, input logic exp_ack);
      logic a;
      send_start();
      write_byte(ab, a);
      chk({req, " address ack"}, int'(a), int'(exp_ack));
      for (int j = 0; j < n; j++) begin
         write_byte(wdata[j], a);
         chk({req, " data ack"}, int'(a), int'(exp_ack));
      end
   endtask

   task automatic model_write(input int n);
      for (int j = 0; j < n; j++) rx_model[j % 8] = wdata[j];
      if (n % 8 != 0)
         for (int k = 0; k < n % 8; k++) model[k] = rx_model[k] + 8'd1;
   endtask

   task automatic rd_xfer(input string req, input int n);
      logic a;
      logic [7:0] b;
      send_start();
      write_byte(8'h21, a);
      chk({req, " read address ack"}, int'(a), 1);
      for (int j = 0; j < n; j++) begin
         read_byte(j != n - 1, b);
         chk({req, " read byte"}, int'(b), int'(model[j % 8]));
      end
      half();
      chk("R9 SDA released after NACK", int'(sda_oe), 0);
      send_stop();
      half();
   endtask

   initial begin
      for (int k = 0; k < 8; k++) begin
         model[k] = 8'h00;
         rx_model[k] = 8'h00;
      end
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk("R1 sda_oe", int'(sda_oe), 0);
      chk("R1 scl_oe", int'(scl_oe), 0);
      chk("R1 rx_count", int'(rx_count), 0);
      rd_xfer("R1 R2 R8 reset contents", 3);

      // R5 R6 R2 sweep over write lengths
      for (int len = 1; len <= 7; len++) begin
         for (int j = 0; j < len; j++) wdata[j] = 8'((len * 29 + j * 71 + 195) & 255);
         if (len == 4) wdata[3] = 8'hFF;
         wr_xfer("R2 R5 sweep", 8'h20, len, 1'b1);
         half();
         chk("R5 rx_count before STOP", int'(rx_count), len);
         send_stop();
         half();
         chk("R6 rx_count after STOP", int'(rx_count), 0);
         model_write(len);
         rd_xfer("R6 R8 sweep readback", 8);
      end

      // R8 wrap of transmit index
      rd_xfer("R8 wrap", 9);

      // R4 wrong address ignored
      wdata[0] = 8'h5A; wdata[1] = 8'hA5;
      wr_xfer("R4 foreign address", 8'h22, 2, 1'b0);
      half();
      chk("R4 rx_count unchanged", int'(rx_count), 0);
      chk("R4 sda released", int'(sda_oe), 0);
      send_stop();
      half();
      rd_xfer("R4 contents unchanged", 8);

      // R3 address zero as write
      wdata[0] = 8'h10; wdata[1] = 8'h7F;
      wr_xfer("R3 address zero", 8'h00, 2, 1'b1);
      half();
      chk("R3 rx_count", int'(rx_count), 2);
      send_stop();
      half();
      model_write(2);
      rd_xfer("R3 readback", 8);

      // R7 write of exactly depth bytes copies nothing
      for (int j = 0; j < 8; j++) wdata[j] = 8'(j * 17 + 3);
      wr_xfer("R7 full depth", 8'h20, 8, 1'b1);
      half();
      chk("R7 rx_count wrapped", int'(rx_count), 0);
      send_stop();
      half();
      model_write(8);
      rd_xfer("R7 no copy", 8);

      // R5 R6 nine bytes: index wraps to 1, only entry 0 updated
      for (int j = 0; j < 9; j++) wdata[j] = 8'(200 - j * 13);
      wr_xfer("R5 nine bytes", 8'h20, 9, 1'b1);
      half();
      chk("R5 rx_count after wrap", int'(rx_count), 1);
      send_stop();
      half();
      model_write(9);
      rd_xfer("R6 partial copy", 8);

      // R10 repeated START, no copy until STOP
      begin
         logic a;
         logic [7:0] b;
         wdata[0] = 8'h40;
         wr_xfer("R10 write before restart", 8'h20, 1, 1'b1);
         send_start();
         write_byte(8'h21, a);
         chk("R10 read address ack after restart", int'(a), 1);
         read_byte(1'b0, b);
         chk("R10 old entry before STOP", int'(b), int'(model[0]));
         half();
         chk("R10 rx_count kept", int'(rx_count), 1);
         send_stop();
         half();
         model_write(1);
         chk("R10 rx_count after STOP", int'(rx_count), 0);
         rd_xfer("R10 copy after STOP", 2);
      end

      chk("R11 scl never driven", int'(scl_driven), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule